// File: doc/BRIEF.md
# Paged Hex Display Selector

This block presents a 128-bit word on a bank of eight seven-segment digits. Eight digits hold only eight hex characters, so the word is split into four 32-bit pages. A 2-bit page select chooses which page is shown. The select input is brought into the clock domain through two flip-flops before it is used.

The block scans the digits one at a time. A divider counts down from the system clock so that each digit is lit for a fixed dwell period. By default that gives each digit about 1 kHz refresh from a 100 MHz clock. While a digit is lit, its nibble of the selected page is decoded to a hex glyph. Anode and segment lines are both active low. The word input is decoded combinationally, so a change to it appears on the segments in the same cycle.

Top module: `hexpage_display`

## Requirements
- R1: While `rst_n` is low, every anode and every segment is off (`an_n` and `seg_n` all ones). In the first cycle after release, digit 0 (`an_n[0]` low, the rightmost) is lit.
- R2: After reset, exactly one bit of `an_n` is low in every cycle.
- R3: The lit digit advances 0,1,...,7 and then wraps back to 0. Digit k is shown by `an_n[k]` low.
- R4: With page p selected, digit k shows bits [32p+4k+3 : 32p+4k] of `value`. Page 0 therefore holds bits [31:0] and page 3 holds bits [127:96]. Changes on `value` show on `seg_n` without a clock delay.
- R5: `seg_n` is {g,f,e,d,c,b,a}, from bit 6 down to bit 0, and active low. The glyphs, written as active-high gfedcba, are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.
- R6: A new `page_sel` value, set up before a clock edge, takes effect on the displayed page after the second rising edge. After only the first edge, the old page is still shown.
- R7: Each digit stays lit for CLK_HZ/(DIGIT_HZ*DIGITS) cycles. The default is 12500 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| value | input | 128 | Word to display |
| page_sel | input | 2 | Page select, asynchronous to clk |
| an_n | output | 8 | Digit enables, active low, bit 0 rightmost |
| seg_n | output | 7 | Segments g..a, active low |

## Verification
A corrupt scan counter is seen at once. It shows up as a second lit anode or none at all, or as a dwell time other than the nominal period. The bench catches this within one dwell period by checking the anode position every cycle. A wrong page or nibble index shows up as a wrong glyph on the first digit that is affected. A stuck or short synchronizer shows up two edges after a page change, because the bench checks both the old and the new page at that boundary.

// File: rtl/hexpage_display.sv
module hexpage_display #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int DIGIT_HZ = 1_000,
  parameter int DIGITS   = 8,
  parameter int WORD_W   = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WORD_W-1:0]             value,
  input  logic [$clog2(WORD_W/(DIGITS*4))-1:0] page_sel,
  output logic [DIGITS-1:0]             an_n,
  output logic [6:0]                    seg_n
);
  localparam int PAGE_W = DIGITS * 4;
  localparam int PAGES  = WORD_W / PAGE_W;
  localparam int SW     = $clog2(PAGES);
  localparam int STEP   = CLK_HZ / (DIGIT_HZ * DIGITS);
  localparam int CW     = $clog2(STEP + 1);
  localparam int IW     = $clog2(DIGITS);

  logic [SW-1:0]     sel_s1, sel_s2;
  logic [CW-1:0]     div_cnt;
  logic [IW-1:0]     dig_idx;
  logic              tick;
  logic [PAGE_W-1:0] page_word;
  logic [3:0]        nib;
  logic [6:0]        glyph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_s1 <= '0;
      sel_s2 <= '0;
    end else begin
      sel_s1 <= page_sel;
      sel_s2 <= sel_s1;
    end
  end

  assign tick = (div_cnt == CW'(STEP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      dig_idx <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      dig_idx <= (dig_idx == IW'(DIGITS - 1)) ? '0 : dig_idx + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign page_word = value[int'(sel_s2) * PAGE_W +: PAGE_W];
  assign nib       = page_word[int'(dig_idx) * 4 +: 4];

  always_comb begin
    case (nib)
      4'h0: glyph = 7'h3F;
      4'h1: glyph = 7'h06;
      4'h2: glyph = 7'h5B;
      4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66;
      4'h5: glyph = 7'h6D;
      4'h6: glyph = 7'h7D;
      4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F;
      4'h9: glyph = 7'h6F;
      4'hA: glyph = 7'h77;
      4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39;
      4'hD: glyph = 7'h5E;
      4'hE: glyph = 7'h79;
      default: glyph = 7'h71;
    endcase
  end

  assign an_n  = rst_n ? ~(DIGITS'(1) << dig_idx) : '1;
  assign seg_n = rst_n ? ~glyph : '1;

  // R1: scanning starts on the rightmost digit
  p_first_digit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !an_n[0]);

  p_one_anode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~an_n) == 1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && $past(rst_n)) |=> $stable(an_n));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !an_n[DIGITS-1]) |=> !an_n[0]);

  p_div_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < CW'(STEP));
endmodule

// File: tb/hexpage_display_tb_top.sv
module hexpage_display_tb_top;
  localparam int STEP = 4;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [127:0] value = '0;
  logic [1:0]   page_sel = '0;
  logic [7:0]   an_n;
  logic [6:0]   seg_n;

  int checks = 0;
  int fails = 0;
  int n = 0;
  logic [1:0] cur_page = '0;

  always #4 clk = ~clk;

  hexpage_display #(.CLK_HZ(8000), .DIGIT_HZ(250), .DIGITS(8), .WORD_W(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .value(value), .page_sel(page_sel),
    .an_n(an_n), .seg_n(seg_n));

  always @(posedge clk) n <= rst_n ? n + 1 : 0;

  function automatic logic [6:0] glyph_of(input logic [3:0] d);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return t[d];
  endfunction

  function automatic logic [3:0] nib_of(input logic [127:0] v, input int p, input int k);
    return v[p*32 + k*4 +: 4];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  task automatic check_now(input string tag);
    int d;
    d = (n / STEP) % 8;
    chk({tag, " R2/R3 anode"}, {24'h0, an_n}, {24'h0, ~(8'b1 << d)});
    chk({tag, " R4/R5 segments"}, {25'h0, seg_n},
        {25'h0, ~glyph_of(nib_of(value, cur_page, d))});
  endtask

  task automatic set_page(input logic [1:0] p);
    page_sel = p;
    step(2);
    cur_page = p;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] old_p;
    int run;
    logic [7:0] last;
    void'($urandom(32'h5EED1234));
    step(3);
    chk("R1 anodes off in reset", {24'h0, an_n}, 32'hFF);
    chk("R1 segments off in reset", {25'h0, seg_n}, 32'h7F);
    rst_n = 1;
    #1;
    chk("R1 digit0 after release", {24'h0, an_n}, 32'hFE);

    value = 128'hFEDCBA98_76543210_0123_4567_89AB_CDEF;
    for (int p = 0; p < 4; p++) begin
      set_page(2'(p));
      for (int c = 0; c < 40; c++) begin check_now("R3 scan"); step(1); end
    end

    run = 0; last = an_n;
    for (int c = 0; c < 64; c++) begin
      step(1);
      if (an_n === last) run++;
      else begin
        if (c > 8) chk("R7 dwell", run + 1, STEP);
        run = 0; last = an_n;
      end
    end

    while (an_n !== 8'h7F) step(1);
    step(STEP);
    chk("R3 wrap to digit0", {24'h0, an_n}, 32'hFE);

    value = 128'hFFFFFFFF_EEEEEEEE_11111111_00000000;
    set_page(0);
    page_sel = 2'd3;
    step(1);
    check_now("R6 old page after one edge");
    step(1);
    cur_page = 2'd3;
    check_now("R6 new page after two edges");

    for (int i = 0; i < 300; i++) begin
      value = {$urandom, $urandom, $urandom, $urandom};
      #1;
      check_now("R4 immediate value");
      if (($urandom % 4) == 0) begin
        old_p = 2'($urandom);
        set_page(old_p);
      end
      step(1 + ($urandom % 5));
      check_now("R5 random");
    end

    rst_n = 0;
    step(1);
    chk("R1 blank mid-run reset", {24'h0, an_n}, 32'hFF);
    rst_n = 1;
    #1;
    chk("R1 restart at digit0", {24'h0, an_n}, 32'hFE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule